// File: doc/BRIEF.md
# Low-Power Mode Entry/Exit Tracker

This block follows one memory channel through its low-power states. Each cycle it watches the clock-enable input and a decoded row command. It decides whether the channel is in normal operation, in power-down, in self-refresh, or in the exit window that leads back from one of them. A low-power state can only be entered from normal operation. Entry happens in the cycle where clock-enable drops. The row command present in that same cycle picks the mode: a no-operation picks power-down, and a refresh of all banks or of a single bank picks self-refresh.

To leave a low-power state, the controller drives clock-enable high with a no-operation on the row bus. The tracker then holds an exit window whose length is an input value in cycles. One input gives the length for power-down and another gives it for self-refresh. The value is taken from the input in the cycle the exit command is seen. A value that was changed while the channel was asleep therefore applies to that exit.

A one-cycle error strobe reports two kinds of misuse: a command that is not allowed while the channel is asleep or leaving sleep, and an entry attempt with an unsuitable command. A one-cycle pulse marks each self-refresh entry, so that a refresh-interval monitor can restart its timers.

Top module: `lp_mode_tracker`

## Requirements
- R1: After asynchronous reset, `lp_state` is 0 (normal), `busy` is 0, and both `cmd_err` and `sr_enter` are 0.
- R2: In normal state, if `cke` is low in a cycle after a cycle with `cke` high and `row_cmd` is 0 (no-operation), `lp_state` becomes 1 (power-down) after that clock edge.
- R3: In normal state, a `cke` fall with `row_cmd` 4 (refresh all banks) or 5 (refresh one bank) moves `lp_state` to 2 (self-refresh). `sr_enter` is high for exactly the cycle after that edge.
- R4: In normal state, a `cke` fall with any other `row_cmd` value (1, 2, 3, 6, 7) pulses `cmd_err` for one cycle, and `lp_state` stays 0.
- R5: In states 1 and 2, while `cke` is low, `row_cmd` and the latency inputs have no effect: the state holds and no error is raised. `cke` held low in normal state without a preceding high cycle causes no entry.
- R6: In state 1 or 2, `cke` high with `row_cmd` 0 starts an exit window. The state is 3 (leaving power-down) or 4 (leaving self-refresh) for exactly L cycles and then 0. L is `pd_exit_lat` or `sr_exit_lat` respectively. L = 0 returns to state 0 directly.
- R7: L is the latency input value present in the cycle the exit command is sampled. Earlier values, including those present at entry, are not used.
- R8: In state 1 or 2, `cke` high with a non-zero `row_cmd` pulses `cmd_err`, and the state holds. During an exit window any non-zero `row_cmd` pulses `cmd_err`, and the window count continues unchanged.
- R9: `busy` is 1 exactly when `lp_state` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock-enable pin level |
| row_cmd | input | 3 | Decoded row command: 0 no-op, 1 activate, 2 precharge, 3 precharge all, 4 refresh all, 5 refresh one bank, 6/7 other |
| pd_exit_lat | input | LAT_W | Power-down exit latency in cycles |
| sr_exit_lat | input | LAT_W | Self-refresh exit latency in cycles |
| lp_state | output | 3 | 0 normal, 1 power-down, 2 self-refresh, 3 leaving power-down, 4 leaving self-refresh |
| busy | output | 1 | High in any state other than normal |
| cmd_err | output | 1 | One-cycle illegal-command strobe |
| sr_enter | output | 1 | One-cycle pulse on self-refresh entry |

## Verification
Directed sequences cover each entry command at a `cke` fall, which separates power-down entry, self-refresh entry, and a rejected entry. Exits are run with latencies of zero, one and several cycles; this tells a correct window length from an off-by-one count. One sequence changes the latency while the channel is asleep, which shows whether the value is sampled at exit or at entry. Random runs of `cke` and commands then mix misuse inside sleep and inside exit windows, and a bench model predicts every output on every cycle.

// File: rtl/lp_mode_tracker.sv
module lp_mode_tracker #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic [2:0]       row_cmd,
  input  logic [LAT_W-1:0] pd_exit_lat,
  input  logic [LAT_W-1:0] sr_exit_lat,
  output logic [2:0]       lp_state,
  output logic             busy,
  output logic             cmd_err,
  output logic             sr_enter
);

  localparam logic [2:0] ST_NORM = 3'd0;
  localparam logic [2:0] ST_PD   = 3'd1;
  localparam logic [2:0] ST_SR   = 3'd2;
  localparam logic [2:0] ST_PDX  = 3'd3;
  localparam logic [2:0] ST_SRX  = 3'd4;

  localparam logic [2:0] CMD_NOP   = 3'd0;
  localparam logic [2:0] CMD_REF   = 3'd4;
  localparam logic [2:0] CMD_REFSB = 3'd5;

  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  logic [2:0]       state_q, state_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             cke_q;
  logic             err_d, sre_d;
  logic             is_nop, is_ref, cke_fall, asleep;
  logic [LAT_W-1:0] exit_lat;

  assign is_nop   = (row_cmd == CMD_NOP);
  assign is_ref   = (row_cmd == CMD_REF) || (row_cmd == CMD_REFSB);
  assign cke_fall = cke_q && !cke;
  assign asleep   = (state_q == ST_PD) || (state_q == ST_SR);
  assign exit_lat = (state_q == ST_PD) ? pd_exit_lat : sr_exit_lat;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    err_d   = 1'b0;
    sre_d   = 1'b0;
    if (state_q == ST_NORM) begin
      if (cke_fall) begin
        if (is_nop) begin
          state_d = ST_PD;
        end else if (is_ref) begin
          state_d = ST_SR;
          sre_d   = 1'b1;
        end else begin
          err_d = 1'b1;
        end
      end
    end else if (asleep) begin
      if (cke) begin
        if (!is_nop) begin
          err_d = 1'b1;
        end else if (exit_lat == '0) begin
          state_d = ST_NORM;
        end else begin
          state_d = (state_q == ST_PD) ? ST_PDX : ST_SRX;
          cnt_d   = exit_lat;
        end
      end
    end else begin
      err_d = !is_nop;
      if (cnt_q <= ONE) begin
        state_d = ST_NORM;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_NORM;
      cnt_q    <= '0;
      cke_q    <= 1'b0;
      cmd_err  <= 1'b0;
      sr_enter <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cke_q    <= cke;
      cmd_err  <= err_d;
      sr_enter <= sre_d;
    end
  end

  assign lp_state = state_q;
  assign busy     = (state_q != ST_NORM);

endmodule

// File: rtl/lp_mode_tracker_chk.sv
module lp_mode_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cke_q,
  input logic [2:0] row_cmd,
  input logic [2:0] lp_state,
  input logic       cmd_err,
  input logic       sr_enter
);

  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == 3'd0 && cke_q && !cke && row_cmd == 3'd0) |=> (lp_state == 3'd1)); // R2

  AST_SR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |-> (lp_state == 3'd2)); // R3

  AST_SR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |=> !sr_enter); // R3

  AST_BAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == 3'd0 && cke_q && !cke && row_cmd != 3'd0 && row_cmd != 3'd4 && row_cmd != 3'd5)
    |=> (cmd_err && lp_state == 3'd0)); // R4

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_state == 3'd1 || lp_state == 3'd2) && !cke) |=> ($stable(lp_state) && !cmd_err)); // R5

  AST_EXIT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == 3'd3) |=> (lp_state == 3'd3 || lp_state == 3'd0)); // R6

  AST_EXIT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_state == 3'd3 || lp_state == 3'd4) && row_cmd != 3'd0) |=> cmd_err); // R8

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lp_state <= 3'd4); // R9

endmodule

bind lp_mode_tracker lp_mode_tracker_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cke      (cke),
  .cke_q    (cke_q),
  .row_cmd  (row_cmd),
  .lp_state (lp_state),
  .cmd_err  (cmd_err),
  .sr_enter (sr_enter)
);

// File: tb/lp_mode_tracker_bench.sv
module lp_mode_tracker_bench;
  localparam int LAT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cke = 1'b1;
  logic [2:0]       row_cmd = 3'd0;
  logic [LAT_W-1:0] pd_exit_lat = '0;
  logic [LAT_W-1:0] sr_exit_lat = '0;
  logic [2:0]       lp_state;
  logic             busy, cmd_err, sr_enter;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]       m_state;
  logic [LAT_W-1:0] m_cnt;
  logic             m_ckeq, m_err, m_sre;

  always #2.5 clk = ~clk;

  lp_mode_tracker #(.LAT_W(LAT_W)) u_lp_mode_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .row_cmd(row_cmd),
    .pd_exit_lat(pd_exit_lat), .sr_exit_lat(sr_exit_lat),
    .lp_state(lp_state), .busy(busy), .cmd_err(cmd_err), .sr_enter(sr_enter)
  );

  task automatic model_step();
    logic [LAT_W-1:0] l;
    m_err = 0;
    m_sre = 0;
    case (m_state)
      3'd0: if (m_ckeq && !cke) begin
        if (row_cmd == 3'd0) m_state = 3'd1;
        else if (row_cmd == 3'd4 || row_cmd == 3'd5) begin m_state = 3'd2; m_sre = 1; end
        else m_err = 1;
      end
      3'd1, 3'd2: if (cke) begin
        if (row_cmd != 3'd0) m_err = 1;
        else begin
          l = (m_state == 3'd1) ? pd_exit_lat : sr_exit_lat;
          if (l == 0) m_state = 3'd0;
          else begin m_state = (m_state == 3'd1) ? 3'd3 : 3'd4; m_cnt = l; end
        end
      end
      default: begin
        if (row_cmd != 3'd0) m_err = 1;
        if (m_cnt <= 1) m_state = 3'd0;
        else m_cnt = m_cnt - 1;
      end
    endcase
    m_ckeq = cke;
  endtask

  function automatic logic [5:0] pack_exp();
    return {m_state, (m_state != 3'd0), m_err, m_sre};
  endfunction

  task automatic check(string req);
    logic [5:0] act;
    act = {lp_state, busy, cmd_err, sr_enter};
    checks++;
    if (act !== pack_exp()) begin
      errors++;
      $display("FAIL %s: {state,busy,err,sre} actual=%b expected=%b at %0t", req, act, pack_exp(), $time);
    end
  endtask

  task automatic step(input logic c, input logic [2:0] cmd, string req);
    @(negedge clk);
    cke = c;
    row_cmd = cmd;
    @(posedge clk);
    model_step();
    #1;
    check(req);
  endtask

  task automatic expect_state(logic [2:0] exp, string req);
    checks++;
    if (lp_state !== exp) begin
      errors++;
      $display("FAIL %s: lp_state actual=%0d expected=%0d", req, lp_state, exp);
    end
  endtask

  initial begin
    int n;
    logic [31:0] seed;
    m_state = 0; m_cnt = 0; m_ckeq = 0; m_err = 0; m_sre = 0;
    seed = $urandom(32'h0005eed1);
    #12;
    check("R1");
    @(negedge clk) rst_n = 1'b1;

    step(1, 0, "R5"); step(1, 0, "R5");
    step(0, 3'd6, "R5");
    step(0, 3'd0, "R5");
    step(1, 0, "R9");
    // power-down entry, held, exit with latency 3
    step(0, 3'd0, "R2"); expect_state(3'd1, "R2");
    step(0, 3'd2, "R5"); step(0, 3'd7, "R5");
    pd_exit_lat = 8'd3;
    step(1, 3'd1, "R8"); expect_state(3'd1, "R8");
    step(1, 3'd0, "R6");
    n = 0;
    while (lp_state == 3'd3 && n < 20) begin step(1, 0, "R6"); n++; end
    checks++;
    if (n != 3) begin errors++; $display("FAIL R6: exit window actual=%0d expected=3", n); end
    // self-refresh entry via single-bank refresh, latency change during sleep
    sr_exit_lat = 8'd2;
    step(1, 0, "R9");
    step(0, 3'd5, "R3");
    checks++;
    if (sr_enter !== 1'b1) begin errors++; $display("FAIL R3: sr_enter actual=%b expected=1", sr_enter); end
    step(0, 0, "R3");
    sr_exit_lat = 8'd5;
    step(0, 0, "R7");
    step(1, 3'd0, "R7");
    n = 0;
    while (lp_state == 3'd4 && n < 20) begin
      step(1, (n == 1) ? 3'd3 : 3'd0, (n == 1) ? "R8" : "R7");
      n++;
    end
    checks++;
    if (n != 5) begin errors++; $display("FAIL R7: exit window actual=%0d expected=5", n); end
    // refresh-all entry, zero latency exit
    sr_exit_lat = 8'd0;
    step(1, 0, "R9");
    step(0, 3'd4, "R3");
    step(1, 3'd0, "R6"); expect_state(3'd0, "R6");
    // bad entry
    step(1, 0, "R4");
    step(0, 3'd2, "R4");
    checks++;
    if (cmd_err !== 1'b1 || lp_state !== 3'd0) begin
      errors++; $display("FAIL R4: err=%b state=%0d expected err=1 state=0", cmd_err, lp_state);
    end
    step(0, 3'd0, "R5");
    // latency 1 power-down
    pd_exit_lat = 8'd1;
    step(1, 0, "R6"); step(0, 0, "R2"); step(1, 0, "R6"); step(1, 0, "R6");
    expect_state(3'd0, "R6");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic c;
      logic [2:0] cmd;
      c = (($urandom % 6) == 0) ? ~cke : cke;
      cmd = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom % 8);
      if (($urandom % 8) == 0) pd_exit_lat = LAT_W'($urandom % 7);
      if (($urandom % 8) == 0) sr_exit_lat = LAT_W'($urandom % 7);
      step(c, cmd, "R2 R3 R4 R5 R6 R8 R9 random");
    end

    // async reset from a low-power state
    step(1, 0, "R1"); step(0, 3'd4, "R1");
    #1 rst_n = 1'b0;
    m_state = 0; m_cnt = 0; m_ckeq = 0; m_err = 0; m_sre = 0;
    #1 check("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule